// File: doc/BRIEF.md
# Lockable Two-Stage Watchdog Timer

This block is a bus-attached watchdog. A down-counter runs once software sets the enable bit. The first time the counter reaches zero, the block raises a timeout interrupt and reloads the counter from the load register. If the timeout is still pending when the counter next reaches zero, and reset generation is enabled, the block asserts a system reset request. That request stays asserted until the block itself is reset. Software services the watchdog by clearing the interrupt. Clearing it also restarts the counter from the load value.

The register bus is word-addressed and single-cycle: a write takes effect at the clock edge, and read data is combinational from the address. A lock register guards the control and load registers against stray writes. Writing the unlock key opens them, and writing any other value closes them. A test register holds a stall bit. While the stall bit is set, a debug-halt input freezes the counter.

Register map (byte offsets; an offset with its two low bits nonzero, or above 0x1C, is not decoded, reads 0 and ignores writes): 0x00 load, 0x04 count (read only), 0x08 control (bit 0 enable, bit 1 reset enable), 0x0C interrupt clear (bit 0, reads 0), 0x10 raw status (bit 0), 0x14 masked status (bit 0), 0x18 lock, 0x1C test (bit 0 stall).

Top module: `wdt_guard`

## Requirements
- R1: After reset the load and count registers hold all ones. The enable, reset-enable, raw status, stall and lock state are all 0, and wdt_irq and sys_rst_req are low.
- R2: While enable (control bit 0) is 0, the counter holds its value. Writing 1 to control bit 0 starts counting, and control reads back bit 0 = 1 while the counter runs.
- R3: When running and not stalled, the count falls by one each cycle. In the cycle after the count is 0, the count becomes the load value and raw status bit 0 becomes 1.
- R4: A timeout that occurs while raw status is already 1 and control bit 1 is 1 sets sys_rst_req, which then stays high until reset. With control bit 1 clear, timeouts never set sys_rst_req.
- R5: An accepted write to the load register sets both load and count to the written value in the next cycle. Writing 0 also sets raw status to 1.
- R6: Writing 32'h1ACCE551 to the lock register unlocks, and writing any other value locks. The lock register reads 1 when locked and 0 when unlocked.
- R7: While locked, writes to the load and control registers change nothing. Interrupt-clear and test writes still act.
- R8: Raw status bit 0 shows the pending timeout whatever the enable bit is. Masked status bit 0 and wdt_irq show raw status AND enable.
- R9: Writing 1 to interrupt-clear bit 0 clears raw status and reloads the count from the load register, so a pending timeout cannot turn into a reset.
- R10: With test bit 0 set and dbg_halt high, the count holds. With test bit 0 clear, the count advances regardless of dbg_halt.
- R11: The enable bit is sticky: writing 0 to control bit 0 does not clear it; only reset does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| dbg_halt | input | 1 | Debug halt; freezes counting when stall is enabled |
| wdt_irq | output | 1 | Timeout interrupt (masked status) |
| sys_rst_req | output | 1 | Sticky system reset request |

## Verification
The assertions assume that reset is held high for at least one clock before any checked behaviour, and that bus_wr is a clean one-cycle strobe whose address and data are stable across the edge. They also assume dbg_halt is synchronous to clk. The bench changes every input only on the falling edge and holds reset for two cycles. It draws load values from a small range so that timeouts, second timeouts and zero loads happen often. It sends lock writes both as the key and as random values, so the locked and unlocked paths both get exercised.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int DW      = 32;
    localparam int REG_LSB = 2;
    localparam int IDX_W   = 3;

    localparam logic [DW-1:0] UNLOCK_KEY = 32'h1ACCE551;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_RST_BIT  = 1;
    localparam int CLR_TO_BIT    = 0;
    localparam int TEST_STALL_BIT = 0;

    typedef enum logic [IDX_W-1:0] {
        REG_LOAD  = 3'd0,
        REG_COUNT = 3'd1,
        REG_CTRL  = 3'd2,
        REG_CLR   = 3'd3,
        REG_RAW   = 3'd4,
        REG_MSK   = 3'd5,
        REG_LOCK  = 3'd6,
        REG_TEST  = 3'd7
    } wdt_reg_e;

    typedef struct packed {
        logic load_wr;
        logic ctrl_wr;
        logic clr_wr;
        logic lock_wr;
        logic test_wr;
    } wdt_strobe_t;

    typedef struct packed {
        logic [DW-1:0] load;
        logic [DW-1:0] count;
        logic          en;
        logic          rst_en;
        logic          ris;
        logic          stall;
        logic          locked;
    } wdt_view_t;

    function automatic logic [DW-1:0] zext1(input logic b);
        return {{(DW-1){1'b0}}, b};
    endfunction
endpackage

// File: rtl/wdt_decode.sv
module wdt_decode
    import wdt_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  wdt_view_t         view,
    output wdt_strobe_t       strb,
    output logic [DW-1:0]     rdata
);
    localparam int TOP_LSB = REG_LSB + IDX_W;

    logic     aligned;
    logic     hit;
    wdt_reg_e idx;

    assign aligned = (bus_addr[REG_LSB-1:0] == '0) && ((bus_addr >> TOP_LSB) == '0);
    assign idx     = wdt_reg_e'(bus_addr[REG_LSB +: IDX_W]);
    assign hit     = bus_wr && aligned;

    always_comb begin
        strb = '0;
        if (hit) begin
            case (idx)
                REG_LOAD: strb.load_wr = 1'b1;
                REG_CTRL: strb.ctrl_wr = 1'b1;
                REG_CLR:  strb.clr_wr  = 1'b1;
                REG_LOCK: strb.lock_wr = 1'b1;
                REG_TEST: strb.test_wr = 1'b1;
                default:  strb = '0;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        if (aligned) begin
            case (idx)
                REG_LOAD:  rdata = view.load;
                REG_COUNT: rdata = view.count;
                REG_CTRL:  rdata = zext1(view.en) | (zext1(view.rst_en) << CTRL_RST_BIT);
                REG_CLR:   rdata = '0;
                REG_RAW:   rdata = zext1(view.ris);
                REG_MSK:   rdata = zext1(view.ris && view.en);
                REG_LOCK:  rdata = zext1(view.locked);
                REG_TEST:  rdata = zext1(view.stall) << TEST_STALL_BIT;
                default:   rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/wdt_lock.sv
module wdt_lock
    import wdt_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          lock_wr,
    input  logic [DW-1:0] wdata,
    output logic          locked_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            locked_q <= 1'b0;
        end else if (lock_wr) begin
            locked_q <= (wdata != UNLOCK_KEY);
        end
    end

    // R6: the key opens, anything else closes
    p_key_opens_r6: assert property (@(posedge clk) disable iff (rst)
        (lock_wr && wdata == UNLOCK_KEY) |=> !locked_q);
    p_other_closes_r6: assert property (@(posedge clk) disable iff (rst)
        (lock_wr && wdata != UNLOCK_KEY) |=> locked_q);
    p_lock_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !lock_wr |=> $stable(locked_q));
endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter logic [DW-1:0] RESET_LOAD = '1
) (
    input  logic          clk,
    input  logic          rst,
    input  wdt_strobe_t   strb,
    input  logic [DW-1:0] wdata,
    input  logic          locked,
    input  logic          dbg_halt,
    output logic [DW-1:0] load_q,
    output logic [DW-1:0] count_q,
    output logic          en_q,
    output logic          rst_en_q,
    output logic          ris_q,
    output logic          stall_q,
    output logic          rst_req_q
);
    logic ld_acc;
    logic ctl_acc;
    logic clr;
    logic tick;
    logic expire;

    assign ld_acc  = strb.load_wr && !locked;
    assign ctl_acc = strb.ctrl_wr && !locked;
    assign clr     = strb.clr_wr && wdata[CLR_TO_BIT];
    assign tick    = en_q && !(stall_q && dbg_halt);
    assign expire  = tick && (count_q == '0) && !ld_acc && !clr;

    // configuration bits
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= 1'b0;
            rst_en_q <= 1'b0;
            stall_q  <= 1'b0;
            load_q   <= RESET_LOAD;
        end else begin
            if (ctl_acc) begin
                en_q     <= en_q | wdata[CTRL_EN_BIT];
                rst_en_q <= wdata[CTRL_RST_BIT];
            end
            if (strb.test_wr) begin
                stall_q <= wdata[TEST_STALL_BIT];
            end
            if (ld_acc) begin
                load_q <= wdata;
            end
        end
    end

    // counter, pending timeout, reset request
    always_ff @(posedge clk) begin
        if (rst) begin
            count_q   <= RESET_LOAD;
            ris_q     <= 1'b0;
            rst_req_q <= 1'b0;
        end else begin
            if (ld_acc) begin
                count_q <= wdata;
            end else if (clr || expire) begin
                count_q <= load_q;
            end else if (tick) begin
                count_q <= count_q - 1'b1;
            end

            if (ld_acc && wdata == '0) begin
                ris_q <= 1'b1;
            end else if (clr) begin
                ris_q <= 1'b0;
            end else if (expire) begin
                ris_q <= 1'b1;
            end

            if (expire && ris_q && rst_en_q) begin
                rst_req_q <= 1'b1;
            end
        end
    end

    // R2: idle counter holds
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!en_q && !strb.load_wr && !strb.clr_wr) |=> $stable(count_q));
    // R3: one step per cycle
    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        (en_q && !stall_q && count_q != '0 && !strb.load_wr && !strb.clr_wr)
        |=> (count_q == $past(count_q) - 1'b1));
    // R4: reset only after a pending timeout with reset enabled; sticky
    p_rst_cause_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_req_q) |-> $past(ris_q && rst_en_q));
    p_rst_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        rst_req_q |=> rst_req_q);
    // R5: accepted load copies into counter
    p_load_copy_r5: assert property (@(posedge clk) disable iff (rst)
        (strb.load_wr && !locked) |=> (count_q == $past(wdata)) && (load_q == $past(wdata)));
    // R7: locked writes ignored
    p_locked_ctrl_r7: assert property (@(posedge clk) disable iff (rst)
        (locked && strb.ctrl_wr) |=> $stable(rst_en_q) && $stable(en_q));
    p_locked_load_r7: assert property (@(posedge clk) disable iff (rst)
        (locked && strb.load_wr) |=> $stable(load_q));
    // R9: clear removes the pending timeout
    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (strb.clr_wr && wdata[CLR_TO_BIT] && !strb.load_wr) |=> !ris_q);
    // R10: stalled counter holds
    p_stall_r10: assert property (@(posedge clk) disable iff (rst)
        (stall_q && dbg_halt && !strb.load_wr && !strb.clr_wr) |=> $stable(count_q));
    // R11: enable is sticky
    p_en_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        en_q |=> en_q);
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
    import wdt_pkg::*;
#(
    parameter int              ADDR_W     = 5,
    parameter logic [DW-1:0]   RESET_LOAD = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic              dbg_halt,
    output logic              wdt_irq,
    output logic              sys_rst_req
);
    wdt_strobe_t   strb;
    wdt_view_t     view;
    logic [DW-1:0] load_q;
    logic [DW-1:0] count_q;
    logic          en_q;
    logic          rst_en_q;
    logic          ris_q;
    logic          stall_q;
    logic          locked_q;
    logic          rst_req_q;

    wdt_decode #(.ADDR_W(ADDR_W)) u_decode (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .view     (view),
        .strb     (strb),
        .rdata    (bus_rdata)
    );

    wdt_lock u_lock (
        .clk      (clk),
        .rst      (rst),
        .lock_wr  (strb.lock_wr),
        .wdata    (bus_wdata),
        .locked_q (locked_q)
    );

    wdt_core #(.RESET_LOAD(RESET_LOAD)) u_core (
        .clk       (clk),
        .rst       (rst),
        .strb      (strb),
        .wdata     (bus_wdata),
        .locked    (locked_q),
        .dbg_halt  (dbg_halt),
        .load_q    (load_q),
        .count_q   (count_q),
        .en_q      (en_q),
        .rst_en_q  (rst_en_q),
        .ris_q     (ris_q),
        .stall_q   (stall_q),
        .rst_req_q (rst_req_q)
    );

    always_comb begin
        view.load   = load_q;
        view.count  = count_q;
        view.en     = en_q;
        view.rst_en = rst_en_q;
        view.ris    = ris_q;
        view.stall  = stall_q;
        view.locked = locked_q;
    end

    assign wdt_irq     = ris_q && en_q;
    assign sys_rst_req = rst_req_q;

    // R8: the interrupt only follows an enabled, pending timeout
    p_irq_gate_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(wdt_irq) |-> (ris_q && en_q));
endmodule

// File: tb/sim_wdt_guard.sv
`timescale 1ns/1ps
module sim_wdt_guard;
    localparam logic [31:0] KEY = 32'h1ACCE551;
    localparam logic [4:0] A_LOAD = 5'h00, A_CNT = 5'h04, A_CTRL = 5'h08, A_CLR = 5'h0C,
                           A_RAW = 5'h10, A_MSK = 5'h14, A_LOCK = 5'h18, A_TEST = 5'h1C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        dbg_halt = 1'b0;
    logic        wdt_irq;
    logic        sys_rst_req;

    int total = 0;
    int bad = 0;
    logic [31:0] last_rd;

    logic [31:0] m_load, m_cnt;
    logic m_en, m_rsten, m_ris, m_rst, m_lock, m_stall;

    always #2.5 clk = ~clk;

    wdt_guard u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dbg_halt(dbg_halt),
        .wdt_irq(wdt_irq), .sys_rst_req(sys_rst_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(input logic [4:0] a);
        if (a[1:0] != 2'b00) return 32'h0;
        case (a[4:2])
            3'd0: return m_load;
            3'd1: return m_cnt;
            3'd2: return {30'h0, m_rsten, m_en};
            3'd4: return {31'h0, m_ris};
            3'd5: return {31'h0, m_ris & m_en};
            3'd6: return {31'h0, m_lock};
            3'd7: return {31'h0, m_stall};
            default: return 32'h0;
        endcase
    endfunction

    task automatic m_reset();
        m_load = '1; m_cnt = '1; m_en = 0; m_rsten = 0;
        m_ris = 0; m_rst = 0; m_lock = 0; m_stall = 0;
    endtask

    task automatic m_step(input logic wr, input logic [4:0] a, input logic [31:0] d, input logic h);
        logic al, ld, ctl, clr, lk, tst, tk, ex;
        logic [31:0] n_cnt;
        logic n_ris;
        al  = (a[1:0] == 2'b00);
        ld  = wr && al && a[4:2] == 3'd0 && !m_lock;
        ctl = wr && al && a[4:2] == 3'd2 && !m_lock;
        clr = wr && al && a[4:2] == 3'd3 && d[0];
        lk  = wr && al && a[4:2] == 3'd6;
        tst = wr && al && a[4:2] == 3'd7;
        tk  = m_en && !(m_stall && h);
        ex  = tk && m_cnt == 0 && !ld && !clr;
        n_cnt = ld ? d : (clr || ex) ? m_load : tk ? m_cnt - 1 : m_cnt;
        n_ris = (ld && d == 0) ? 1'b1 : clr ? 1'b0 : ex ? 1'b1 : m_ris;
        m_rst = m_rst | (ex && m_ris && m_rsten);
        m_cnt = n_cnt;
        m_ris = n_ris;
        if (ld) m_load = d;
        if (ctl) begin m_en = m_en | d[0]; m_rsten = d[1]; end
        if (lk) m_lock = (d != KEY);
        if (tst) m_stall = d[0];
    endtask

    // one bus cycle: drive, compare against model, advance
    task automatic cyc(input string tag, input logic wr, input logic [4:0] a,
                       input logic [31:0] d, input logic h);
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d; dbg_halt = h;
        #1;
        last_rd = bus_rdata;
        chk(tag, bus_rdata, m_read(a));
        chk(tag, {31'h0, wdt_irq}, {31'h0, m_ris & m_en});
        chk(tag, {31'h0, sys_rst_req}, {31'h0, m_rst});
        @(posedge clk);
        m_step(wr, a, d, h);
    endtask

    task automatic wr_reg(input string tag, input logic [4:0] a, input logic [31:0] d);
        cyc(tag, 1'b1, a, d, 1'b0);
    endtask

    task automatic rd_reg(input string tag, input logic [4:0] a);
        cyc(tag, 1'b0, a, 32'h0, 1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; bus_wr = 0;
        repeat (2) @(posedge clk);
        m_reset();
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        m_reset();
        do_reset();

        // R1: reset state
        rd_reg("R1", A_CNT);  chk("R1", last_rd, 32'hFFFF_FFFF);
        rd_reg("R1", A_LOCK); chk("R1", last_rd, 32'h0);
        rd_reg("R1", A_CTRL); chk("R1", last_rd, 32'h0);
        chk("R1", {31'h0, wdt_irq}, 32'h0);

        // R5: load copies; R2: idle holds
        wr_reg("R5", A_LOAD, 32'd3);
        rd_reg("R5", A_CNT); chk("R5", last_rd, 32'd3);
        rd_reg("R2", A_CNT); chk("R2", last_rd, 32'd3);
        wr_reg("R2", A_CTRL, 32'd1);
        rd_reg("R2", A_CTRL); chk("R2", last_rd, 32'd1);
        rd_reg("R3", A_CNT); chk("R3", last_rd, 32'd2);
        rd_reg("R3", A_CNT); chk("R3", last_rd, 32'd1);
        rd_reg("R3", A_CNT); chk("R3", last_rd, 32'd0);
        rd_reg("R3", A_RAW); chk("R3", last_rd, 32'd1);
        chk("R8", {31'h0, wdt_irq}, 32'd1);
        // R9: clear
        wr_reg("R9", A_CLR, 32'd1);
        rd_reg("R9", A_RAW); chk("R9", last_rd, 32'd0);
        chk("R9", {31'h0, wdt_irq}, 32'd0);
        // R11: enable sticky
        wr_reg("R11", A_CTRL, 32'd0);
        rd_reg("R11", A_CTRL); chk("R11", last_rd, 32'd1);

        // R8: raw vs masked with enable off, zero load
        do_reset();
        wr_reg("R5", A_LOAD, 32'd0);
        rd_reg("R8", A_RAW); chk("R8", last_rd, 32'd1);
        rd_reg("R8", A_MSK); chk("R8", last_rd, 32'd0);
        chk("R8", {31'h0, wdt_irq}, 32'd0);

        // R6 / R7: lock
        wr_reg("R6", A_LOCK, 32'd0);
        rd_reg("R6", A_LOCK); chk("R6", last_rd, 32'd1);
        wr_reg("R7", A_LOAD, 32'd7);
        rd_reg("R7", A_LOAD); chk("R7", last_rd, 32'd0);
        wr_reg("R7", A_CTRL, 32'd3);
        rd_reg("R7", A_CTRL); chk("R7", last_rd, 32'd0);
        wr_reg("R7", A_TEST, 32'd1);
        rd_reg("R7", A_TEST); chk("R7", last_rd, 32'd1);
        wr_reg("R6", A_LOCK, KEY);
        rd_reg("R6", A_LOCK); chk("R6", last_rd, 32'd0);
        wr_reg("R6", A_LOAD, 32'd7);
        rd_reg("R6", A_LOAD); chk("R6", last_rd, 32'd7);

        // R4: second timeout resets
        do_reset();
        wr_reg("R4", A_LOAD, 32'd2);
        wr_reg("R4", A_CTRL, 32'd3);
        for (int i = 0; i < 10; i++) rd_reg("R4", A_CNT);
        chk("R4", {31'h0, sys_rst_req}, 32'd1);
        wr_reg("R4", A_CLR, 32'd1);
        rd_reg("R4", A_CNT);
        chk("R4", {31'h0, sys_rst_req}, 32'd1);

        // R4: no reset when reset enable clear
        do_reset();
        wr_reg("R4", A_LOAD, 32'd2);
        wr_reg("R4", A_CTRL, 32'd1);
        for (int i = 0; i < 12; i++) rd_reg("R4", A_CNT);
        chk("R4", {31'h0, sys_rst_req}, 32'd0);
        chk("R4", {31'h0, wdt_irq}, 32'd1);

        // R9: servicing prevents reset
        do_reset();
        wr_reg("R9", A_LOAD, 32'd2);
        wr_reg("R9", A_CTRL, 32'd3);
        for (int i = 0; i < 3; i++) rd_reg("R9", A_CNT);
        wr_reg("R9", A_CLR, 32'd1);
        for (int i = 0; i < 3; i++) rd_reg("R9", A_CNT);
        rd_reg("R9", A_RAW); chk("R9", last_rd, 32'd1);
        chk("R9", {31'h0, sys_rst_req}, 32'd0);

        // R10: stall
        do_reset();
        wr_reg("R10", A_LOAD, 32'd5);
        wr_reg("R10", A_TEST, 32'd1);
        wr_reg("R10", A_CTRL, 32'd1);
        for (int i = 0; i < 4; i++) cyc("R10", 1'b0, A_CNT, 32'h0, 1'b1);
        chk("R10", last_rd, 32'd5);
        cyc("R10", 1'b0, A_CNT, 32'h0, 1'b0);
        cyc("R10", 1'b0, A_CNT, 32'h0, 1'b0);
        chk("R10", last_rd, 32'd4);
        wr_reg("R10", A_TEST, 32'd0);
        cyc("R10", 1'b0, A_CNT, 32'h0, 1'b1);
        cyc("R10", 1'b0, A_CNT, 32'h0, 1'b1);
        chk("R10", last_rd, 32'd1);

        // random phase
        do_reset();
        for (int i = 0; i < 6000; i++) begin
            int unsigned op;
            logic h;
            op = $urandom % 16;
            h  = ($urandom % 4) == 0;
            case (op)
                0, 1: cyc("R5", 1'b1, A_LOAD, $urandom % 12, h);
                2:    cyc("R2", 1'b1, A_CTRL, $urandom % 4, h);
                3:    cyc("R9", 1'b1, A_CLR, $urandom % 2, h);
                4:    cyc("R6", 1'b1, A_LOCK, ($urandom % 2) ? KEY : ($urandom % 8), h);
                5:    cyc("R10", 1'b1, A_TEST, $urandom % 2, h);
                6:    if (($urandom % 8) == 0) do_reset();
                      else cyc("R3", 1'b0, 5'($urandom), 32'h0, h);
                default: cyc("R3", 1'b0, 5'($urandom), 32'h0, h);
            endcase
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule